// File: doc/BRIEF.md
# DRAM Idle Low-Power Ladder

This block watches an activity flag from the memory bus and moves a DRAM interface into deeper low-power states the longer the bus stays quiet. A saturating counter in the interface clock domain measures the current idle run. The interface clock runs at half the DRAM clock rate, so every threshold is a count of half-rate cycles. Five programmable thresholds are compared against that count: power-down, self-refresh, self-refresh power-down, self-refresh with the controller clock stopped, and full standby. The power-down and standby thresholds are raw cycle counts. The three other self-refresh thresholds are multiplied by 2^SCALE_LOG2, which is 1024 by default.

Each time the block enters a level it pulses a one-hot entry request. It also keeps three clock enables up to date: controller, PHY/PI and DRAM. Standby always goes through self-refresh before any clock beyond the controller clock is cut. Bus activity in a low-power level clears the idle count and starts a wake sequence. First every gated clock is turned back on. Then a one-hot exit request for the level being left is held until the memory side answers with an exit-done handshake. The thresholds are captured only while the block is active.

Top module: `lp_idle_ladder`

## Requirements
- R1: After a synchronous reset, lp_level is 0 (active), enter_req and exit_req are all zero, sr_active is 0 and all three clock enables are 1.
- R2: lp_level codes are 0 active, 1 power-down, 2 self-refresh, 3 self-refresh power-down, 4 self-refresh with controller clock gated, 5 standby. With thr_pd = N (N > 0), an idle run that begins after an edge sampling bus_busy high shows lp_level 1 right after the (N+1)-th idle edge and not before.
- R3: The thresholds thr_sr, thr_srpd and thr_srmc count in units of 2^SCALE_LOG2 idle cycles. thr_pd and thr_sby count single cycles.
- R4: The self-refresh power-down level (code 3) is entered only while mem_is_lp4 is 1. Otherwise its threshold is ignored.
- R5: A threshold of 0 disables its level. With every threshold 0, the block stays active however long the bus is idle.
- R6: When several thresholds are met, the deepest met level is entered directly, using the order 1 < 2 < 3 < 4 < 5. Entering level k pulses enter_req bit k-1 (bit0 power-down … bit4 standby) for exactly one cycle. At most one bit is ever high.
- R7: Standby is reached through self-refresh. From a level below 2, the block first enters level 2 for one cycle and then level 5. Clock enables are: level 4 clears clk_en_mc only; level 5 clears all three; every other level keeps all three at 1. sr_active is 1 in levels 2 to 5.
- R8: In the first cycle after a low-power level samples bus_busy high, all clock enables are 1 and exit_req is still 0. From the next cycle, exit_req bit k-1 for the level being left stays high until exit_done is sampled high. The block then returns to active with exit_req 0. Bus activity while active clears the idle count.
- R9: The idle counter saturates. An idle run of any length never moves the block to a shallower level.
- R10: Threshold inputs are captured only while active. A change made during a low-power level takes effect only after the block returns to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface (half-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | Memory bus activity flag, high = not idle |
| mem_is_lp4 | input | 1 | Memory type select, high = LPDDR4 |
| exit_done | input | 1 | Memory side has finished leaving the low-power level |
| thr_pd | input | PD_W | Power-down idle threshold, cycles |
| thr_sr | input | SRX_W | Self-refresh threshold, units of 2^SCALE_LOG2 cycles |
| thr_srmc | input | SRX_W | Self-refresh with controller clock gating threshold, scaled |
| thr_srpd | input | SRX_W | Self-refresh power-down threshold, scaled, LPDDR4 only |
| thr_sby | input | SBY_W | Standby idle threshold, cycles |
| lp_level | output | 3 | Current low-power level code |
| enter_req | output | 5 | One-cycle one-hot entry request per level |
| exit_req | output | 5 | One-hot exit request held until exit_done |
| sr_active | output | 1 | Memory is in a self-refresh level |
| clk_en_mc | output | 1 | Controller clock enable |
| clk_en_phy | output | 1 | PHY/PI clock enable |
| clk_en_dram | output | 1 | DRAM clock enable |

## Verification
The bench counts idle edges exactly and samples one edge before and one edge after each threshold. A comparison that is off by one, or that uses the wrong scale for a threshold, shows up as a level change one cycle early or late, or hundreds of cycles late. The standby run checks the one-cycle stop in self-refresh and the clock enables at each step. A design that cut every clock straight from power-down would show level 5 with no level-2 entry pulse. The wake sequence checks that clocks come back before exit_req rises and that the request holds until the handshake; a design that leaves early returns to level 0 without waiting. Zero thresholds, an LPDDR4-only level with the type select low, thresholds changed while in power-down, and an idle run longer than the counter range all target designs that trigger disabled levels or let the state drift.

// File: rtl/lpl_pkg.sv
package lpl_pkg;

  localparam int NUM_LP = 5;

  // level codes; numeric order is depth order
  localparam logic [2:0] LV_ACT  = 3'd0;
  localparam logic [2:0] LV_PD   = 3'd1;
  localparam logic [2:0] LV_SR   = 3'd2;
  localparam logic [2:0] LV_SRPD = 3'd3;
  localparam logic [2:0] LV_SRMC = 3'd4;
  localparam logic [2:0] LV_SBY  = 3'd5;

  // sequencer phases
  localparam logic [1:0] ST_ACT   = 2'd0;
  localparam logic [1:0] ST_LOWP  = 2'd1;
  localparam logic [1:0] ST_WAKE  = 2'd2;
  localparam logic [1:0] ST_EXREQ = 2'd3;

  function automatic logic [NUM_LP-1:0] lvl_onehot(input logic [2:0] lv);
    logic [NUM_LP-1:0] v;
    v = '0;
    for (int i = 1; i <= NUM_LP; i++) begin
      if (lv == 3'(i)) v[i-1] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/lpl_idle_counter.sv
module lpl_idle_counter #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lpl_thresh_eval.sv
module lpl_thresh_eval
  import lpl_pkg::*;
#(
  parameter int PD_W       = 8,
  parameter int SRX_W      = 8,
  parameter int SBY_W      = 16,
  parameter int SCALE_LOG2 = 10,
  parameter int CNT_W      = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             mem_is_lp4,
  input  logic [PD_W-1:0]  thr_pd,
  input  logic [SRX_W-1:0] thr_sr,
  input  logic [SRX_W-1:0] thr_srmc,
  input  logic [SRX_W-1:0] thr_srpd,
  input  logic [SBY_W-1:0] thr_sby,
  input  logic [CNT_W-1:0] cnt,
  output logic [2:0]       target
);

  // captured thresholds, frozen outside the active phase
  logic [PD_W-1:0]  sh_pd;
  logic [SRX_W-1:0] sh_sr, sh_srmc, sh_srpd;
  logic [SBY_W-1:0] sh_sby;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_pd   <= '0;
      sh_sr   <= '0;
      sh_srmc <= '0;
      sh_srpd <= '0;
      sh_sby  <= '0;
    end else if (load) begin
      sh_pd   <= thr_pd;
      sh_sr   <= thr_sr;
      sh_srmc <= thr_srmc;
      sh_srpd <= thr_srpd;
      sh_sby  <= thr_sby;
    end
  end

  // effective thresholds in idle cycles, indexed by level code - 1
  logic [CNT_W-1:0]  eff [NUM_LP];
  logic [NUM_LP-1:0] allow;

  always_comb begin
    eff[0] = CNT_W'(sh_pd);
    eff[1] = CNT_W'(sh_sr)   << SCALE_LOG2;
    eff[2] = CNT_W'(sh_srpd) << SCALE_LOG2;
    eff[3] = CNT_W'(sh_srmc) << SCALE_LOG2;
    eff[4] = CNT_W'(sh_sby);
    allow    = '1;
    allow[2] = mem_is_lp4;
  end

  logic [NUM_LP-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_LP; g++) begin : g_cmp
      assign hit[g] = allow[g] && (eff[g] != '0) && (cnt >= eff[g]);
    end
  endgenerate

  // deepest met level wins
  always_comb begin
    target = LV_ACT;
    for (int i = 0; i < NUM_LP; i++) begin
      if (hit[i]) target = 3'(i + 1);
    end
  end

endmodule

// File: rtl/lpl_seq.sv
module lpl_seq
  import lpl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_busy,
  input  logic              exit_done,
  input  logic [2:0]        target,
  output logic [1:0]        st,
  output logic [2:0]        level,
  output logic [NUM_LP-1:0] enter_req,
  output logic [NUM_LP-1:0] exit_req,
  output logic              sr_active,
  output logic              clk_en_mc,
  output logic              clk_en_phy,
  output logic              clk_en_dram
);

  logic [1:0]        st_n;
  logic [2:0]        lvl_n, step_lv;
  logic [NUM_LP-1:0] enter_n, exit_n;
  logic              go_deeper;

  // standby is only reached from a self-refresh level
  always_comb begin
    if (target == LV_SBY && level < LV_SR) step_lv = LV_SR;
    else                                   step_lv = target;
  end

  always_comb begin
    st_n      = st;
    lvl_n     = level;
    enter_n   = '0;
    exit_n    = exit_req;
    go_deeper = 1'b0;
    case (st)
      ST_ACT: begin
        if (!bus_busy && target != LV_ACT) go_deeper = 1'b1;
      end
      ST_LOWP: begin
        if (bus_busy)             st_n = ST_WAKE;
        else if (target > level)  go_deeper = 1'b1;
      end
      ST_WAKE: begin
        st_n   = ST_EXREQ;
        exit_n = lvl_onehot(level);
      end
      default: begin
        if (exit_done) begin
          st_n   = ST_ACT;
          lvl_n  = LV_ACT;
          exit_n = '0;
        end
      end
    endcase
    if (go_deeper) begin
      st_n    = ST_LOWP;
      lvl_n   = step_lv;
      enter_n = lvl_onehot(step_lv);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_ACT;
      level       <= LV_ACT;
      enter_req   <= '0;
      exit_req    <= '0;
      sr_active   <= 1'b0;
      clk_en_mc   <= 1'b1;
      clk_en_phy  <= 1'b1;
      clk_en_dram <= 1'b1;
    end else begin
      st          <= st_n;
      level       <= lvl_n;
      enter_req   <= enter_n;
      exit_req    <= exit_n;
      sr_active   <= (lvl_n >= LV_SR);
      clk_en_mc   <= !(st_n == ST_LOWP && lvl_n >= LV_SRMC);
      clk_en_phy  <= !(st_n == ST_LOWP && lvl_n == LV_SBY);
      clk_en_dram <= !(st_n == ST_LOWP && lvl_n == LV_SBY);
    end
  end

endmodule

// File: rtl/lp_idle_ladder.sv
module lp_idle_ladder
  import lpl_pkg::*;
#(
  parameter int SCALE_LOG2 = 10,
  parameter int PD_W       = 8,
  parameter int SRX_W      = 8,
  parameter int SBY_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_busy,
  input  logic              mem_is_lp4,
  input  logic              exit_done,
  input  logic [PD_W-1:0]   thr_pd,
  input  logic [SRX_W-1:0]  thr_sr,
  input  logic [SRX_W-1:0]  thr_srmc,
  input  logic [SRX_W-1:0]  thr_srpd,
  input  logic [SBY_W-1:0]  thr_sby,
  output logic [2:0]        lp_level,
  output logic [NUM_LP-1:0] enter_req,
  output logic [NUM_LP-1:0] exit_req,
  output logic              sr_active,
  output logic              clk_en_mc,
  output logic              clk_en_phy,
  output logic              clk_en_dram
);

  localparam int SCALED_W = SRX_W + SCALE_LOG2;
  localparam int WIDE1    = (PD_W > SCALED_W) ? PD_W : SCALED_W;
  localparam int WIDE2    = (WIDE1 > SBY_W) ? WIDE1 : SBY_W;
  localparam int CNT_W    = WIDE2 + 1;

  logic [CNT_W-1:0] idle_cnt;
  logic [1:0]       st_q;
  logic [2:0]       target;
  logic             cnt_clr;

  assign cnt_clr = bus_busy || (st_q == ST_WAKE) || (st_q == ST_EXREQ);

  lpl_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .cnt (idle_cnt)
  );

  lpl_thresh_eval #(
    .PD_W(PD_W), .SRX_W(SRX_W), .SBY_W(SBY_W),
    .SCALE_LOG2(SCALE_LOG2), .CNT_W(CNT_W)
  ) u_eval (
    .clk        (clk),
    .rst        (rst),
    .load       (st_q == ST_ACT),
    .mem_is_lp4 (mem_is_lp4),
    .thr_pd     (thr_pd),
    .thr_sr     (thr_sr),
    .thr_srmc   (thr_srmc),
    .thr_srpd   (thr_srpd),
    .thr_sby    (thr_sby),
    .cnt        (idle_cnt),
    .target     (target)
  );

  lpl_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .bus_busy    (bus_busy),
    .exit_done   (exit_done),
    .target      (target),
    .st          (st_q),
    .level       (lp_level),
    .enter_req   (enter_req),
    .exit_req    (exit_req),
    .sr_active   (sr_active),
    .clk_en_mc   (clk_en_mc),
    .clk_en_phy  (clk_en_phy),
    .clk_en_dram (clk_en_dram)
  );

endmodule

// File: rtl/lpl_checker.sv
module lpl_checker #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_busy,
  input logic             mem_is_lp4,
  input logic             exit_done,
  input logic [2:0]       lp_level,
  input logic [4:0]       enter_req,
  input logic [4:0]       exit_req,
  input logic             sr_active,
  input logic             clk_en_mc,
  input logic             clk_en_phy,
  input logic             clk_en_dram,
  input logic [1:0]       st,
  input logic [CNT_W-1:0] cnt,
  input logic             clr
);

  p_enter_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(enter_req));

  p_srpd_needs_lp4_r4: assert property (@(posedge clk) disable iff (rst)
    enter_req[2] |-> mem_is_lp4);

  p_sr_before_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_dram) |-> $past(sr_active));

  p_mc_gate_in_sr_r7: assert property (@(posedge clk) disable iff (rst)
    !clk_en_mc |-> sr_active);

  p_clocks_on_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (exit_req != 5'd0) |-> (clk_en_mc && clk_en_phy && clk_en_dram));

  p_busy_wakes_r8: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && bus_busy) |=> (st == 2'd2));

  p_exit_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (exit_req != 5'd0 && !exit_done) |=> (exit_req == $past(exit_req)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    ((&cnt) && !clr) |=> (&cnt));

  p_no_shallower_r9: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && !bus_busy) |=> (lp_level >= $past(lp_level)));

endmodule

bind lp_idle_ladder lpl_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_busy   (bus_busy),
  .mem_is_lp4 (mem_is_lp4),
  .exit_done  (exit_done),
  .lp_level   (lp_level),
  .enter_req  (enter_req),
  .exit_req   (exit_req),
  .sr_active  (sr_active),
  .clk_en_mc  (clk_en_mc),
  .clk_en_phy (clk_en_phy),
  .clk_en_dram(clk_en_dram),
  .st         (st_q),
  .cnt        (idle_cnt),
  .clr        (cnt_clr)
);

// File: tb/lp_idle_ladder_test.sv
`timescale 1ns/1ps
module lp_idle_ladder_test;

  localparam int SCALE_LOG2 = 4;
  localparam int PD_W  = 8;
  localparam int SRX_W = 4;
  localparam int SBY_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_busy = 1'b1;
  logic mem_is_lp4 = 1'b0;
  logic exit_done = 1'b0;
  logic [PD_W-1:0]  thr_pd = '0;
  logic [SRX_W-1:0] thr_sr = '0, thr_srmc = '0, thr_srpd = '0;
  logic [SBY_W-1:0] thr_sby = '0;
  logic [2:0] lp_level;
  logic [4:0] enter_req, exit_req;
  logic sr_active, clk_en_mc, clk_en_phy, clk_en_dram;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lp_idle_ladder #(
    .SCALE_LOG2(SCALE_LOG2), .PD_W(PD_W), .SRX_W(SRX_W), .SBY_W(SBY_W)
  ) uut (
    .clk(clk), .rst(rst), .bus_busy(bus_busy), .mem_is_lp4(mem_is_lp4),
    .exit_done(exit_done), .thr_pd(thr_pd), .thr_sr(thr_sr),
    .thr_srmc(thr_srmc), .thr_srpd(thr_srpd), .thr_sby(thr_sby),
    .lp_level(lp_level), .enter_req(enter_req), .exit_req(exit_req),
    .sr_active(sr_active), .clk_en_mc(clk_en_mc), .clk_en_phy(clk_en_phy),
    .clk_en_dram(clk_en_dram)
  );

  task automatic check(string rq, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_clk(string rq, int mc, int phy, int dram);
    check(rq, "clk_en_mc", int'(clk_en_mc), mc);
    check(rq, "clk_en_phy", int'(clk_en_phy), phy);
    check(rq, "clk_en_dram", int'(clk_en_dram), dram);
  endtask

  task automatic set_thr(int pd, int sr, int srmc, int srpd, int sby);
    thr_pd = PD_W'(pd); thr_sr = SRX_W'(sr); thr_srmc = SRX_W'(srmc);
    thr_srpd = SRX_W'(srpd); thr_sby = SBY_W'(sby);
    tick(2);
  endtask

  // R8: wake and handshake out of level lv
  task automatic wake_and_exit(int lv);
    bus_busy = 1'b1;
    tick(1);
    check("R8", "exit_req in wake cycle", int'(exit_req), 0);
    check_clk("R8", 1, 1, 1);
    tick(1);
    check("R8", "exit_req raised", int'(exit_req), 1 << (lv - 1));
    tick(3);
    check("R8", "exit_req held", int'(exit_req), 1 << (lv - 1));
    check("R8", "level during exit", int'(lp_level), lv);
    exit_done = 1'b1;
    tick(1);
    check("R8", "level after exit_done", int'(lp_level), 0);
    check("R8", "exit_req cleared", int'(exit_req), 0);
    exit_done = 1'b0;
    tick(2);
  endtask

  task automatic t_reset();
    check("R1", "lp_level", int'(lp_level), 0);
    check("R1", "enter_req", int'(enter_req), 0);
    check("R1", "exit_req", int'(exit_req), 0);
    check("R1", "sr_active", int'(sr_active), 0);
    check_clk("R1", 1, 1, 1);
  endtask

  task automatic t_powerdown();
    set_thr(6, 0, 0, 0, 0);
    bus_busy = 1'b0;
    tick(6);
    check("R2", "level before threshold", int'(lp_level), 0);
    tick(1);
    check("R2", "level at threshold", int'(lp_level), 1);
    check("R6", "enter_req pd", int'(enter_req), 5'b00001);
    check("R7", "sr_active in pd", int'(sr_active), 0);
    check_clk("R7", 1, 1, 1);
    tick(1);
    check("R6", "enter_req one cycle", int'(enter_req), 0);
    wake_and_exit(1);
  endtask

  task automatic t_busy_clears();
    set_thr(6, 0, 0, 0, 0);
    bus_busy = 1'b0;
    tick(4);
    bus_busy = 1'b1;
    tick(1);
    bus_busy = 1'b0;
    tick(6);
    check("R8", "count restarted after activity", int'(lp_level), 0);
    tick(1);
    check("R8", "pd after fresh run", int'(lp_level), 1);
    wake_and_exit(1);
  endtask

  task automatic t_zero();
    set_thr(0, 0, 0, 0, 0);
    bus_busy = 1'b0;
    tick(600);
    check("R5", "all disabled stays active", int'(lp_level), 0);
    bus_busy = 1'b1;
    set_thr(0, 1, 0, 0, 0);
    bus_busy = 1'b0;
    tick(16);
    check("R5", "pd disabled, sr not yet", int'(lp_level), 0);
    tick(1);
    check("R3", "sr after 1 scaled unit", int'(lp_level), 2);
    check("R5", "enter_req sr only", int'(enter_req), 5'b00010);
    check("R7", "sr_active", int'(sr_active), 1);
    wake_and_exit(2);
  endtask

  task automatic t_deepest();
    set_thr(3, 1, 1, 0, 0);
    bus_busy = 1'b0;
    tick(4);
    check("R6", "pd first", int'(lp_level), 1);
    check("R6", "enter pd", int'(enter_req), 5'b00001);
    tick(12);
    check("R3", "before scaled threshold", int'(lp_level), 1);
    tick(1);
    check("R6", "deepest level srmc", int'(lp_level), 4);
    check("R6", "enter srmc", int'(enter_req), 5'b01000);
    check_clk("R7", 0, 1, 1);
    wake_and_exit(4);
  endtask

  task automatic t_lp4();
    set_thr(0, 1, 0, 1, 0);
    bus_busy = 1'b0;
    tick(17);
    check("R4", "non-lp4 stops at sr", int'(lp_level), 2);
    wake_and_exit(2);
    mem_is_lp4 = 1'b1;
    tick(2);
    bus_busy = 1'b0;
    tick(17);
    check("R4", "lp4 reaches srpd", int'(lp_level), 3);
    check("R4", "enter srpd", int'(enter_req), 5'b00100);
    check_clk("R7", 1, 1, 1);
    wake_and_exit(3);
    mem_is_lp4 = 1'b0;
  endtask

  task automatic t_standby();
    set_thr(3, 0, 0, 0, 20);
    bus_busy = 1'b0;
    tick(4);
    check("R7", "pd before standby", int'(lp_level), 1);
    tick(17);
    check("R7", "self-refresh step", int'(lp_level), 2);
    check("R7", "enter sr step", int'(enter_req), 5'b00010);
    check_clk("R7", 1, 1, 1);
    tick(1);
    check("R7", "standby", int'(lp_level), 5);
    check("R7", "enter standby", int'(enter_req), 5'b10000);
    check("R7", "sr_active standby", int'(sr_active), 1);
    check_clk("R7", 0, 0, 0);
    wake_and_exit(5);
  endtask

  task automatic t_saturate();
    set_thr(5, 0, 0, 0, 0);
    bus_busy = 1'b0;
    tick(700);
    check("R9", "long idle keeps pd", int'(lp_level), 1);
    check("R9", "no new entry", int'(enter_req), 0);
    wake_and_exit(1);
  endtask

  task automatic t_shadow();
    set_thr(5, 0, 0, 0, 0);
    bus_busy = 1'b0;
    tick(6);
    check("R10", "pd entered", int'(lp_level), 1);
    thr_sr = SRX_W'(1);
    tick(100);
    check("R10", "late threshold ignored", int'(lp_level), 1);
    wake_and_exit(1);
    bus_busy = 1'b0;
    tick(16);
    check("R10", "pd on re-entry", int'(lp_level), 1);
    tick(1);
    check("R10", "new sr threshold used", int'(lp_level), 2);
    wake_and_exit(2);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_powerdown();
    t_busy_clears();
    t_zero();
    t_deepest();
    t_lp4();
    t_standby();
    t_saturate();
    t_shadow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule